// File: doc/BRIEF.md
# Interrupt Priority Arbitration Controller

This block decides which pending interrupt a small signal-processing core should take next. Seven programmable sources feed it: two external request pins (active low) and five on-chip peripheral lines (codec, host, serial port 0, serial port 1, timer). Each one gets a two-bit level code from a 16-bit priority register. The external pins also carry a trigger-mode bit. Four fixed exception sources sit above all of them at level 3: hardware reset, illegal instruction, stack error and software interrupt. These cannot be masked.

Each cycle the block drops every programmable source whose level is below the two-bit mask from the core's status register. It then picks one winner. The winner's ID, its level and a valid strobe are presented from registers. When the core acknowledges the offered source, the block clears that source's falling-edge latch if it has one. It then leaves the strobe low while the request state settles, and after that arbitrates again.

A three-state machine controls the strobe. ST_IDLE offers nothing. ST_OFFER presents a winner. ST_GAP is the pause after an acknowledge. The transitions are:
- ST_IDLE to ST_OFFER when any request is eligible.
- ST_OFFER to ST_GAP on acknowledge.
- ST_OFFER to ST_IDLE when no request is eligible any more.
- ST_OFFER stays in ST_OFFER otherwise, and the winner is refreshed every cycle.
- ST_GAP to ST_IDLE always.

Top module: `intr_arbiter`

## Requirements
- R1: The priority register resets to 0x0000. While `cfg_sel` is high, a write with `cfg_we` high loads `cfg_wdata`. A write with `cfg_sel` low leaves it unchanged. `cfg_rdata` always shows its contents.
- R2: The register fields are: pin A level in bits 1:0, pin A trigger mode in bit 2, pin B level in bits 4:3, pin B trigger mode in bit 5, codec in bits 7:6, host in bits 9:8, serial port 0 in bits 11:10, serial port 1 in bits 13:12, and timer in bits 15:14. A level code of 00 disables the source. Codes 01, 10 and 11 give levels 0, 1 and 2.
- R3: A programmable source of level L is eligible only if L >= `mask_lvl`. With a mask of 3, no programmable source is eligible.
- R4: Among eligible programmable sources, the highest level wins. A tie goes to the first in the order pin A (ID 0), pin B (1), codec (2), host (3), serial port 0 (4), serial port 1 (5), timer (6). `grant_lvl` carries the winner's level.
- R5: Exception requests `exc_req[0..3]` are hardware reset, illegal instruction, stack error and software interrupt. They are reported as IDs 8, 9, 10 and 11, at level 3. No mask value blocks them. They beat every programmable source, and a lower index wins among them.
- R6: With a trigger bit of 0, a pin requests while it is low. Nothing is latched, so releasing the pin withdraws the request.
- R7: With a trigger bit of 1, a 1-to-0 change in the registered pin sample sets a latch. The latch holds the request after the pin returns high and is cleared only by an acknowledge of that pin.
- R8: Outputs are registered. For a level-sensitive or peripheral source, the winner computed from the inputs of one cycle appears on `grant_valid`, `grant_id` and `grant_lvl` after the next clock edge. When nothing is eligible, `grant_valid` is low.
- R9: `ack` while `grant_valid` is high forces `grant_valid` low for the next two cycles (ST_GAP, then ST_IDLE). Arbitration then resumes. When `grant_valid` is low, `ack` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sel | input | 1 | Priority register address decode |
| cfg_we | input | 1 | Write enable |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Priority register contents |
| mask_lvl | input | 2 | Status-register interrupt mask |
| pin_a_n | input | 1 | External request pin A, active low |
| pin_b_n | input | 1 | External request pin B, active low |
| periph_req | input | 5 | Codec, host, serial 0, serial 1, timer requests (bit 0 = codec) |
| exc_req | input | 4 | Reset, illegal, stack error, software interrupt (bit 0 = reset) |
| ack | input | 1 | Core acknowledges the offered source |
| grant_valid | output | 1 | A winner is offered |
| grant_id | output | 4 | Winner ID |
| grant_lvl | output | 2 | Winner level |

## Verification
The situation hardest to reach from the ports is an edge-latched pin request that outlives its pin. To build it, the stimulus gives pin A a falling-edge trigger, pulses the pin low for two cycles and releases it. It then confirms that the offer persists with the pin high and that only an acknowledge removes it. Masking and tie-breaking are covered by a sweep over every mask value, every combination of the seven programmable request lines and a spread of register contents, all compared with arithmetic expected values.

// File: rtl/intr_arb_pkg.sv
package intr_arb_pkg;
    localparam int NPROG   = 7;
    localparam int NPIN    = 2;
    localparam int NPERIPH = NPROG - NPIN;
    localparam int NEXC    = 4;
    localparam int IDW     = 4;
    localparam int LVLW    = 2;
    localparam int REGW    = 16;
    localparam logic [IDW-1:0] EXC_ID_BASE = 4'd8;

    typedef enum logic [1:0] {ST_IDLE, ST_OFFER, ST_GAP} arb_state_e;

    // Start bit of each source's two-bit level code inside the register.
    function automatic int code_pos(input int src);
        case (src)
            0: code_pos = 0;
            1: code_pos = 3;
            default: code_pos = 2 * src + 2;
        endcase
    endfunction

    // Trigger-mode bit of external pin p.
    function automatic int mode_pos(input int p);
        mode_pos = 3 * p + 2;
    endfunction
endpackage

// File: rtl/intr_prio_reg.sv
module intr_prio_reg
    import intr_arb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel,
    input  logic            we,
    input  logic [REGW-1:0] wdata,
    output logic [REGW-1:0] value
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            value <= '0;
        else if (sel && we)
            value <= wdata;
    end

    a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sel && we) |-> value == $past(wdata));
    a_r1_unselected_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sel && we) |-> $stable(value));
endmodule

// File: rtl/intr_pin_cond.sv
module intr_pin_cond
    import intr_arb_pkg::*;
#(
    parameter int N = NPIN
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_n,
    input  logic [N-1:0] edge_mode,
    input  logic [N-1:0] clr,
    output logic [N-1:0] req
);
    for (genvar i = 0; i < N; i++) begin : g_pin
        logic samp_q, samp_qq, latch_q, fall;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                samp_q  <= 1'b1;
                samp_qq <= 1'b1;
            end else begin
                samp_q  <= pin_n[i];
                samp_qq <= samp_q;
            end
        end

        assign fall = samp_qq && !samp_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                latch_q <= 1'b0;
            else if (!edge_mode[i] || clr[i])
                latch_q <= 1'b0;
            else if (fall)
                latch_q <= 1'b1;
        end

        assign req[i] = edge_mode[i] ? latch_q : !pin_n[i];

        a_r7_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
            $past(latch_q && edge_mode[i] && !clr[i]) && edge_mode[i] |-> latch_q);
        a_r6_no_latch_level: assert property (@(posedge clk) disable iff (!rst_n)
            $past(!edge_mode[i]) |-> !latch_q);
    end
endmodule

// File: rtl/intr_select.sv
module intr_select
    import intr_arb_pkg::*;
(
    input  logic [2*NPROG-1:0] codes,
    input  logic [NPROG-1:0]   req,
    input  logic [NEXC-1:0]    exc,
    input  logic [LVLW-1:0]    mask,
    output logic               win_v,
    output logic [IDW-1:0]     win_id,
    output logic [LVLW-1:0]    win_lvl
);
    always_comb begin
        win_v   = 1'b0;
        win_id  = '0;
        win_lvl = '0;
        // Programmable sources: strictly higher level replaces, so earlier index keeps ties.
        for (int i = 0; i < NPROG; i++) begin
            logic [1:0] c;
            c = codes[2*i +: 2];
            if (req[i] && c != 2'b00 && c > mask) begin
                if (!win_v || (c - 2'd1) > win_lvl) begin
                    win_v   = 1'b1;
                    win_id  = IDW'(i);
                    win_lvl = c - 2'd1;
                end
            end
        end
        // Exceptions override; scan from lowest priority so index 0 lands last.
        for (int k = NEXC - 1; k >= 0; k--) begin
            if (exc[k]) begin
                win_v   = 1'b1;
                win_id  = EXC_ID_BASE + IDW'(k);
                win_lvl = 2'd3;
            end
        end
    end
endmodule

// File: rtl/intr_arbiter.sv
module intr_arbiter
    import intr_arb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_sel,
    input  logic               cfg_we,
    input  logic [REGW-1:0]    cfg_wdata,
    output logic [REGW-1:0]    cfg_rdata,
    input  logic [LVLW-1:0]    mask_lvl,
    input  logic               pin_a_n,
    input  logic               pin_b_n,
    input  logic [NPERIPH-1:0] periph_req,
    input  logic [NEXC-1:0]    exc_req,
    input  logic               ack,
    output logic               grant_valid,
    output logic [IDW-1:0]     grant_id,
    output logic [LVLW-1:0]    grant_lvl
);
    logic [REGW-1:0]    prio;
    logic [2*NPROG-1:0] codes;
    logic [NPIN-1:0]    edge_mode, pin_clr, pin_req;
    logic [NPROG-1:0]   all_req;
    logic               win_v;
    logic [IDW-1:0]     win_id;
    logic [LVLW-1:0]    win_lvl;
    arb_state_e         state_q, state_d;
    logic               take;

    intr_prio_reg u_reg (
        .clk(clk), .rst_n(rst_n), .sel(cfg_sel), .we(cfg_we),
        .wdata(cfg_wdata), .value(prio)
    );
    assign cfg_rdata = prio;

    for (genvar s = 0; s < NPROG; s++) begin : g_code
        assign codes[2*s +: 2] = prio[code_pos(s) +: 2];
    end
    for (genvar p = 0; p < NPIN; p++) begin : g_mode
        assign edge_mode[p] = prio[mode_pos(p)];
        assign pin_clr[p]   = take && grant_id == IDW'(p);
    end

    intr_pin_cond #(.N(NPIN)) u_pins (
        .clk(clk), .rst_n(rst_n), .pin_n({pin_b_n, pin_a_n}),
        .edge_mode(edge_mode), .clr(pin_clr), .req(pin_req)
    );
    assign all_req = {periph_req, pin_req};

    intr_select u_sel (
        .codes(codes), .req(all_req), .exc(exc_req), .mask(mask_lvl),
        .win_v(win_v), .win_id(win_id), .win_lvl(win_lvl)
    );

    assign take = ack && state_q == ST_OFFER;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = win_v ? ST_OFFER : ST_IDLE;
            ST_OFFER: state_d = ack ? ST_GAP : (win_v ? ST_OFFER : ST_IDLE);
            ST_GAP:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant_valid <= 1'b0;
            grant_id    <= '0;
            grant_lvl   <= '0;
        end else begin
            grant_valid <= (state_d == ST_OFFER);
            grant_id    <= win_id;
            grant_lvl   <= win_lvl;
        end
    end

    a_r3_mask_respected: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid && grant_lvl != 2'd3 |-> grant_lvl >= $past(mask_lvl));
    a_r5_reset_first: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid && $past(exc_req[0]) |-> grant_id == EXC_ID_BASE);
    a_r9_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
        ack && grant_valid |=> !grant_valid);
    a_r4_legal_id: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (grant_id < IDW'(NPROG)) ||
                        (grant_id >= EXC_ID_BASE && grant_lvl == 2'd3));
endmodule

// File: tb/intr_arbiter_test.sv
module intr_arbiter_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_sel = 1'b0, cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0, cfg_rdata;
    logic [1:0]  mask_lvl = '0;
    logic        pin_a_n = 1'b1, pin_b_n = 1'b1;
    logic [4:0]  periph_req = '0;
    logic [3:0]  exc_req = '0;
    logic        ack = 1'b0;
    logic        grant_valid;
    logic [3:0]  grant_id;
    logic [1:0]  grant_lvl;

    int total = 0, bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intr_arbiter uut (
        .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mask_lvl(mask_lvl),
        .pin_a_n(pin_a_n), .pin_b_n(pin_b_n), .periph_req(periph_req),
        .exc_req(exc_req), .ack(ack), .grant_valid(grant_valid),
        .grant_id(grant_id), .grant_lvl(grant_lvl)
    );

    task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_grant(input string req, input logic v, input logic [3:0] id, input logic [1:0] lv);
        if (!v) check(req, {6'd0, grant_valid}, 7'd0);
        else    check(req, {grant_valid, grant_id, grant_lvl}, {1'b1, id, lv});
    endtask

    task automatic write_reg(input logic [15:0] v, input logic sel);
        @(negedge clk);
        cfg_sel = sel; cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_sel = 1'b0; cfg_we = 1'b0;
    endtask

    // Expected winner from the requirement rules (bit r: 0 pinA .. 6 timer).
    function automatic logic [6:0] model(input logic [15:0] cfg, input logic [1:0] m,
                                         input logic [6:0] r, input logic [3:0] e);
        logic [6:0] res;
        int best;
        res = '0; best = -1;
        for (int s = 0; s < 7; s++) begin
            int pos, c;
            pos = (s == 0) ? 0 : (s == 1) ? 3 : 2 * s + 2;
            c = int'(cfg[pos +: 2]);
            if (r[s] && c != 0 && c - 1 >= int'(m) && c - 1 > best) begin
                best = c - 1;
                res = {1'b1, 4'(s), 2'(c - 1)};
            end
        end
        for (int k = 3; k >= 0; k--)
            if (e[k]) res = {1'b1, 4'(8 + k), 2'd3};
        return res;
    endfunction

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] cfg;
        logic [6:0]  exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 reset register", cfg_rdata[6:0], 7'd0);
        check("R8 reset valid", {6'd0, grant_valid}, 7'd0);
        write_reg(16'hBEEF, 1'b0);
        check("R1 unselected write ignored", cfg_rdata[6:0], 7'd0);
        write_reg(16'h5A3C, 1'b1);
        total++;
        if (cfg_rdata !== 16'h5A3C) begin
            bad++; $display("FAIL R1 readback actual=%h expected=5a3c", cfg_rdata);
        end

        // R2 R3 R4 R6 R8 sweep, pins in level mode
        for (int t = 0; t < 64; t++) begin
            cfg = 16'((t * 40503 + 7919) & 16'hFFDB);
            write_reg(cfg, 1'b1);
            for (int m = 0; m < 4; m++) begin
                for (int r = 0; r < 128; r++) begin
                    logic [6:0] rv;
                    rv = 7'(r);
                    mask_lvl = 2'(m);
                    pin_a_n = !rv[0]; pin_b_n = !rv[1];
                    periph_req = rv[6:2];
                    @(negedge clk);
                    exp = model(cfg, 2'(m), rv, 4'd0);
                    check("R2 R3 R4 R6 R8 sweep", {grant_valid, grant_id, grant_lvl},
                          exp[6] ? exp : {grant_valid, grant_id, grant_lvl} & 7'h3F);
                end
            end
        end
        pin_a_n = 1'b1; pin_b_n = 1'b1; periph_req = '0;
        @(negedge clk);
        check_grant("R8 idle no request", 1'b0, 4'd0, 2'd0);

        // R5 exception ordering and unmaskability
        write_reg(16'hFFDB, 1'b1);
        mask_lvl = 2'd3; periph_req = 5'h1F;
        @(negedge clk);
        check_grant("R3 mask 3 blocks programmable", 1'b0, 4'd0, 2'd0);
        for (int e = 1; e < 16; e++) begin
            exc_req = 4'(e);
            mask_lvl = 2'(e & 3);
            @(negedge clk);
            exp = model(16'hFFDB, 2'(e & 3), 7'h7C, 4'(e));
            check("R5 exception order", {grant_valid, grant_id, grant_lvl}, exp);
        end
        exc_req = '0; periph_req = '0; mask_lvl = 2'd0;

        // R9 ack with a held level request: two low cycles then re-offer
        write_reg(16'h4000, 1'b1);  // timer level 0
        periph_req = 5'b10000;
        @(negedge clk);
        check_grant("R9 offer before ack", 1'b1, 4'd6, 2'd0);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        check_grant("R9 gap cycle 1", 1'b0, 4'd0, 2'd0);
        @(negedge clk);
        check_grant("R9 gap cycle 2", 1'b0, 4'd0, 2'd0);
        @(negedge clk);
        check_grant("R9 re-offer", 1'b1, 4'd6, 2'd0);
        periph_req = '0;
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        check_grant("R9 ack while idle ignored", 1'b0, 4'd0, 2'd0);

        // R6 level mode: releasing the pin withdraws
        write_reg(16'h0003, 1'b1);  // pin A level 2, level mode
        pin_a_n = 1'b0;
        @(negedge clk);
        check_grant("R6 level pin held", 1'b1, 4'd0, 2'd2);
        pin_a_n = 1'b1;
        @(negedge clk);
        check_grant("R6 level pin released", 1'b0, 4'd0, 2'd0);

        // R7 edge mode: latch survives pin release until ack
        write_reg(16'h0007, 1'b1);  // pin A level 2, falling edge
        repeat (2) @(negedge clk);
        pin_a_n = 1'b0;
        repeat (2) @(negedge clk);
        pin_a_n = 1'b1;
        repeat (4) @(negedge clk);
        check_grant("R7 latched after release", 1'b1, 4'd0, 2'd2);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        repeat (4) @(negedge clk);
        check_grant("R7 latch cleared by ack", 1'b0, 4'd0, 2'd0);
        pin_a_n = 1'b0;
        repeat (6) @(negedge clk);
        check_grant("R7 held low gives one edge", 1'b1, 4'd0, 2'd2);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        repeat (4) @(negedge clk);
        check_grant("R7 no retrigger while low", 1'b0, 4'd0, 2'd0);
        pin_a_n = 1'b1;

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule